// File: doc/BRIEF.md
# Configurable Interrupt Pin Controller

This block merges a small set of event sources into a single external interrupt line. Each source arrives as a one-cycle strobe. The strobe sets a sticky bit in a status register, and the host clears that bit by writing a 1 to it. A per-event mask decides which of the recorded events may drive the line. A configuration register holds a master enable for the line, a choice between level and pulse signalling, and the active polarity of the line.

The host reaches the three registers through a plain synchronous write port and a combinational read port that share one address. Events are always recorded, whatever the mask and the master enable hold. This lets software poll sources that it keeps away from the line. After power-on, every status bit reads as pending and the line stays quiet. To arm the line, software clears the whole status register and then sets the master enable.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset the status register reads 0x007F, the mask and the configuration read 0, and the line is inactive (driven high, because reset selects active-low).
- R2: The address map is: 0 = status (bits 6:0), 1 = event mask (bits 6:0), 2 = configuration (bit 0 master enable, bit 1 pulse mode when 1, bit 2 active-high when 1), 3 = reads zero. Bits written beyond these fields are dropped, and those bits read as 0.
- R3: An event strobe on bit i sets status bit i at the next clock edge, whatever the mask and the configuration hold.
- R4: A host write to address 0 clears each status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: When an event strobe and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R6: The line can be active only when the master enable is 1 and at least one status bit is set with its mask bit also set. The line follows that condition with one cycle of delay.
- R7: In level mode the line stays active for as long as the condition of R6 holds, and it goes inactive one cycle after the condition ends.
- R8: In pulse mode, each change of the R6 condition from false to true gives one active pulse of exactly PULSE_W cycles, which begins one cycle after the change. Further events while the condition stays true give no new pulse.
- R9: Configuration bit 2 selects the drive level: with 1 the active level is high, with 0 it is low.
- R10: Clearing the master enable makes the line inactive from the next cycle onwards, and this also cuts short a pulse already in progress.
- R11: If software clears all status bits and then sets the master enable, the line stays inactive until a new masked-in event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| evtStrobe | input | NUM_EVT | One-cycle event strobes, one per status bit |
| hostWr | input | 1 | Host write strobe for the register at hostAddr |
| hostAddr | input | 2 | Register address for both reads and writes |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Contents of the addressed register, zero-extended |
| intPin | output | 1 | Interrupt line, with configurable polarity and trigger mode |

## Verification
A corrupted status or mask bit shows up on the read port in the same cycle, and it shows up on the line one cycle later as a wrong active or inactive level. A pulse counter that is loaded wrongly or decrements wrongly gives a pulse that is too short, too long or repeated. The bench counts the line cycle by cycle across a whole pulse, and it also checks that no second pulse follows while events stay pending. The way an event strobe and a host clear meet in the same cycle, and the quiet line after re-arming, are checked at the edge where each matters.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

  localparam int HOST_ADDR_W = 2;

  // Register select decoded from the host address (R2)
  typedef enum logic [HOST_ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_CONFIG = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  // Write strobes from control to datapath
  typedef struct packed {
    logic clrStatus;
    logic ldMask;
    logic ldConfig;
  } hostStrobe_t;

  // Configuration fields; bit order fixes the host-visible layout (R2)
  typedef struct packed {
    logic activeHigh; // bit 2
    logic pulseMode;  // bit 1
    logic pinEnable;  // bit 0
  } pinCfg_t;

  localparam int CFG_W = $bits(pinCfg_t);

endpackage

// File: rtl/irq_pin_regs.sv
module irq_pin_regs
  import irq_pin_pkg::*;
#(
  parameter int NUM_EVT = 7,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtStrobe,
  input  logic [DATA_W-1:0]  hostWrData,
  input  hostStrobe_t        strb,
  input  regSel_e            rdSel,
  output logic [DATA_W-1:0]  hostRdData,
  output logic [NUM_EVT-1:0] statusQ,
  output logic [NUM_EVT-1:0] maskQ,
  output pinCfg_t            cfgQ,
  output logic               anyPending
);

  // Status bits: set by a strobe, cleared by a host write of 1; the strobe wins (R3, R4, R5)
  // All bits come out of reset set (R1)
  for (genvar b = 0; b < NUM_EVT; b++) begin : g_status
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statusQ[b] <= 1'b1;
      end else if (evtStrobe[b]) begin
        statusQ[b] <= 1'b1;
      end else if (strb.clrStatus && hostWrData[b]) begin
        statusQ[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      cfgQ  <= '0;
    end else begin
      if (strb.ldMask) begin
        maskQ <= hostWrData[NUM_EVT-1:0];
      end
      if (strb.ldConfig) begin
        cfgQ <= pinCfg_t'(hostWrData[CFG_W-1:0]);
      end
    end
  end

  // Line request condition (R6)
  assign anyPending = cfgQ.pinEnable & (|(statusQ & maskQ));

  // Zero-extended readback (R2)
  always_comb begin
    hostRdData = '0;
    unique case (rdSel)
      SEL_STATUS: hostRdData[NUM_EVT-1:0] = statusQ;
      SEL_MASK:   hostRdData[NUM_EVT-1:0] = maskQ;
      SEL_CONFIG: hostRdData[CFG_W-1:0]   = cfgQ;
      default:    hostRdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_pin_seq.sv
module irq_pin_seq
  import irq_pin_pkg::*;
#(
  parameter int PULSE_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostWr,
  input  logic [HOST_ADDR_W-1:0] hostAddr,
  input  logic                   anyPending,
  input  pinCfg_t                cfg,
  output hostStrobe_t            strb,
  output regSel_e                rdSel,
  output logic                   pinActive
);

  localparam int CNT_W = $clog2(PULSE_W + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_W);

  logic             pendPrev;
  logic             levelQ;
  logic [CNT_W-1:0] pulseCnt;
  logic             pendRise;

  // Address decode into datapath strobes (R2)
  assign rdSel = regSel_e'(hostAddr);

  always_comb begin
    strb = '0;
    if (hostWr) begin
      unique case (rdSel)
        SEL_STATUS: strb.clrStatus = 1'b1;
        SEL_MASK:   strb.ldMask    = 1'b1;
        SEL_CONFIG: strb.ldConfig  = 1'b1;
        default:    strb           = '0;
      endcase
    end
  end

  assign pendRise = anyPending & ~pendPrev;

  // Level register and pulse counter (R7, R8); a master clear aborts the pulse (R10)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendPrev <= 1'b0;
      levelQ   <= 1'b0;
      pulseCnt <= '0;
    end else begin
      pendPrev <= anyPending;
      levelQ   <= anyPending;
      if (!cfg.pinEnable) begin
        pulseCnt <= '0;
      end else if (pendRise) begin
        pulseCnt <= CNT_LOAD;
      end else if (pulseCnt != '0) begin
        pulseCnt <= pulseCnt - 1'b1;
      end
    end
  end

  assign pinActive = cfg.pulseMode ? (pulseCnt != '0) : levelQ;

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_pin_pkg::*;
#(
  parameter int NUM_EVT = 7,
  parameter int DATA_W  = 16,
  parameter int PULSE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtStrobe,
  input  logic               hostWr,
  input  logic [1:0]         hostAddr,
  input  logic [DATA_W-1:0]  hostWrData,
  output logic [DATA_W-1:0]  hostRdData,
  output logic               intPin
);

  hostStrobe_t        strb;
  regSel_e            rdSel;
  logic [NUM_EVT-1:0] statusQ;
  logic [NUM_EVT-1:0] maskQ;
  pinCfg_t            cfgQ;
  logic               anyPending;
  logic               pinActive;

  irq_pin_seq #(
    .PULSE_W (PULSE_W)
  ) u_seq (
    .clk        (clk),
    .rstN       (rstN),
    .hostWr     (hostWr),
    .hostAddr   (hostAddr),
    .anyPending (anyPending),
    .cfg        (cfgQ),
    .strb       (strb),
    .rdSel      (rdSel),
    .pinActive  (pinActive)
  );

  irq_pin_regs #(
    .NUM_EVT (NUM_EVT),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .evtStrobe  (evtStrobe),
    .hostWrData (hostWrData),
    .strb       (strb),
    .rdSel      (rdSel),
    .hostRdData (hostRdData),
    .statusQ    (statusQ),
    .maskQ      (maskQ),
    .cfgQ       (cfgQ),
    .anyPending (anyPending)
  );

  // Polarity applied at the line (R9); reset gives inactive-high (R1)
  assign intPin = cfgQ.activeHigh ? pinActive : ~pinActive;

endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk #(
  parameter int NUM_EVT = 7,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EVT-1:0] evtStrobe,
  input logic               hostWr,
  input logic [1:0]         hostAddr,
  input logic [DATA_W-1:0]  hostWrData,
  input logic               intPin,
  input logic [NUM_EVT-1:0] statusQ,
  input logic [NUM_EVT-1:0] maskQ,
  input logic [2:0]         cfgBits
);

  // R3
  evt_sets_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtStrobe) |=> ((statusQ & $past(evtStrobe)) == $past(evtStrobe)));

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 2'd0) |=>
      ((statusQ & $past(hostWrData[NUM_EVT-1:0] & ~evtStrobe)) == '0));

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 2'd1) |=> (maskQ == $past(hostWrData[NUM_EVT-1:0])));

  // R10
  master_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgBits[0] && $past(!cfgBits[0])) |-> (intPin == !cfgBits[2]));

  // R7
  level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgBits[0]) && !$past(cfgBits[1]) && !cfgBits[1]) |->
      (intPin == ($past(|(statusQ & maskQ)) ? cfgBits[2] : !cfgBits[2])));

endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk #(
  .NUM_EVT (NUM_EVT),
  .DATA_W  (DATA_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .evtStrobe  (evtStrobe),
  .hostWr     (hostWr),
  .hostAddr   (hostAddr),
  .hostWrData (hostWrData),
  .intPin     (intPin),
  .statusQ    (statusQ),
  .maskQ      (maskQ),
  .cfgBits    (cfgQ)
);

// File: tb/test_irq_pin_ctrl.sv
module test_irq_pin_ctrl;

  localparam int CLK_P   = 10;
  localparam int NUM_EVT = 7;
  localparam int DATA_W  = 16;
  localparam int PULSE_W = 4;

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [15:0] data;
    logic [6:0]  evt;
    logic [1:0]  rdAddr;
    logic [15:0] expRd;
    logic        expPin;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd1, 16'h0005, 7'h00, 2'd1, 16'h0005, 1'b1, 4'd2},  // R2 mask load, master off
    '{1'b1, 2'd2, 16'h0001, 7'h00, 2'd2, 16'h0001, 1'b0, 4'd6},  // R6 master on, pending
    '{1'b1, 2'd0, 16'h007F, 7'h00, 2'd0, 16'h0000, 1'b1, 4'd4},  // R4 clear all
    '{1'b0, 2'd0, 16'h0000, 7'h02, 2'd0, 16'h0002, 1'b1, 4'd3},  // R3 masked-out event
    '{1'b0, 2'd0, 16'h0000, 7'h04, 2'd0, 16'h0006, 1'b0, 4'd6},  // R6 masked-in event
    '{1'b1, 2'd0, 16'h0002, 7'h00, 2'd0, 16'h0004, 1'b0, 4'd4},  // R4 partial clear
    '{1'b1, 2'd0, 16'h0004, 7'h04, 2'd0, 16'h0004, 1'b0, 4'd5},  // R5 strobe beats clear
    '{1'b1, 2'd0, 16'h0004, 7'h00, 2'd0, 16'h0000, 1'b1, 4'd7},  // R7 level drops
    '{1'b1, 2'd2, 16'h0005, 7'h00, 2'd2, 16'h0005, 1'b0, 4'd9},  // R9 active-high idle
    '{1'b0, 2'd0, 16'h0000, 7'h01, 2'd0, 16'h0001, 1'b1, 4'd9},  // R9 active-high asserted
    '{1'b1, 2'd2, 16'h0004, 7'h00, 2'd2, 16'h0004, 1'b0, 4'd10}, // R10 master off
    '{1'b0, 2'd0, 16'h0000, 7'h00, 2'd3, 16'h0000, 1'b0, 4'd2},  // R2 unused address
    '{1'b1, 2'd2, 16'hFFFC, 7'h00, 2'd2, 16'h0004, 1'b0, 4'd2},  // R2 config extra bits dropped
    '{1'b1, 2'd1, 16'hFFFF, 7'h00, 2'd1, 16'h007F, 1'b0, 4'd2}   // R2 mask extra bits dropped
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_EVT-1:0] evtStrobe = '0;
  logic               hostWr = 1'b0;
  logic [1:0]         hostAddr = '0;
  logic [DATA_W-1:0]  hostWrData = '0;
  logic [DATA_W-1:0]  hostRdData;
  logic               intPin;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_pin_ctrl #(
    .NUM_EVT (NUM_EVT),
    .DATA_W  (DATA_W),
    .PULSE_W (PULSE_W)
  ) i_irq_pin_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .evtStrobe  (evtStrobe),
    .hostWr     (hostWr),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .intPin     (intPin)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [15:0] d);
    hostWr = 1'b1; hostAddr = a; hostWrData = d;
    step();
    hostWr = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [1:0] a, input logic [15:0] exp);
    hostAddr = a;
    #1;
    check(req, hostRdData, exp);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readCheck("R1", 2'd0, 16'h007F);
    readCheck("R1", 2'd1, 16'h0000);
    readCheck("R1", 2'd2, 16'h0000);
    check("R1", {15'b0, intPin}, 16'h0001);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      hostWr = VECS[i].wr; hostAddr = VECS[i].addr;
      hostWrData = VECS[i].data; evtStrobe = VECS[i].evt;
      step();
      hostWr = 1'b0; evtStrobe = '0; hostAddr = VECS[i].rdAddr;
      step();
      check($sformatf("R%0d vec%0d rd", VECS[i].req, i), hostRdData, VECS[i].expRd);
      check($sformatf("R%0d vec%0d pin", VECS[i].req, i), {15'b0, intPin}, {15'b0, VECS[i].expPin});
    end

    // R8 pulse mode, active-low
    hostWrite(2'd0, 16'h007F);
    hostWrite(2'd1, 16'h0001);
    hostWrite(2'd2, 16'h0003);
    step();
    check("R8 idle", {15'b0, intPin}, 16'h0001);
    evtStrobe = 7'h01;
    step();
    evtStrobe = '0;
    check("R8 pre", {15'b0, intPin}, 16'h0001);
    for (int j = 0; j < PULSE_W; j++) begin
      step();
      check("R8 pulse", {15'b0, intPin}, 16'h0000);
    end
    step();
    check("R8 end", {15'b0, intPin}, 16'h0001);
    evtStrobe = 7'h01;
    step();
    evtStrobe = '0;
    for (int j = 0; j < PULSE_W + 2; j++) begin
      step();
      check("R8 no repeat", {15'b0, intPin}, 16'h0001);
    end

    // R10 master clear cuts a pulse short
    hostWrite(2'd0, 16'h0001);
    step();
    evtStrobe = 7'h01;
    step();
    evtStrobe = '0;
    step();
    check("R10 pulse on", {15'b0, intPin}, 16'h0000);
    hostWrite(2'd2, 16'h0002);
    step();
    check("R10 aborted", {15'b0, intPin}, 16'h0001);

    // R11 re-arm in level mode
    hostWrite(2'd0, 16'h007F);
    hostWrite(2'd2, 16'h0001);
    for (int j = 0; j < 3; j++) begin
      step();
      check("R11 quiet", {15'b0, intPin}, 16'h0001);
    end
    evtStrobe = 7'h01;
    step();
    evtStrobe = '0;
    step();
    check("R11 fires", {15'b0, intPin}, 16'h0000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule